// File: doc/BRIEF.md
# Posted Store Queue with Refill Overtake

This block sits between a processor core and the internal system bus. Stores from the core are posted into a small in-order queue and leave for the bus one at a time, each retired only when the bus takes it. A cache line refill read may overtake the queued stores, provided none of them writes to the same cache line. Any other read waits until the queue is empty. A barrier request completes only once every earlier access has finished on the bus.

The core presents one request at a time with a valid/ready handshake and a two-bit operation code. Stores are accepted as long as the queue has room. A read or a barrier holds the core port until it completes. Read data returns on a separate pulse. The bus side is a single valid/ready request channel. Read data comes back in the same cycle that the bus accepts a read.

A five-state controller sequences the work. Its states are IDLE, READ_WAIT, READ_RET, SYNC_WAIT and SYNC_DONE. IDLE moves to READ_WAIT on an accepted load or refill, moves to SYNC_WAIT on an accepted barrier, and stays in IDLE on a store. READ_WAIT moves to READ_RET when the bus accepts the read. READ_RET returns to IDLE after one cycle. SYNC_WAIT moves to SYNC_DONE once the queue is empty. SYNC_DONE returns to IDLE after one cycle.

Top module: `wbyp_top`

## Requirements
- R1: The queue holds up to four stores. While four stores are pending, a store request (cpu_op 2'b01) sees cpu_ready low and is not taken.
- R2: Queued stores reach the bus in the order they were accepted, each with its own address and data. A store leaves the queue only on a cycle with bus_valid, bus_ready and bus_we all high.
- R3: A refill read (cpu_op 2'b11) whose 32-byte line (cpu_addr[31:5]) matches no queued store goes on the bus ahead of the remaining queued stores. In a cycle where both the refill and a store could go, the refill wins.
- R4: A refill read whose line matches a queued store is issued only after that store and every older store have been accepted by the bus.
- R5: An ordinary load (cpu_op 2'b00) is issued only when the queue is empty, so it follows every store accepted before it.
- R6: rd_valid is high for exactly the one cycle after the bus accepts a read, and rd_data carries the bus_rdata value from that acceptance.
- R7: A barrier (cpu_op 2'b10) raises sync_done for one cycle, and only after every store accepted before it has been acknowledged by the bus.
- R8: While a read or barrier is outstanding, cpu_ready stays low for any new request.
- R9: Once bus_valid is raised without bus_ready, bus_valid, bus_we, bus_addr and bus_wdata stay unchanged until the bus accepts.
- R10: A synchronous active-high rst empties the queue and drops any pending read or barrier. After reset, bus_valid, rd_valid and sync_done are low, cpu_ready is high, and no discarded store or barrier appears later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Core request valid |
| cpu_ready | output | 1 | Core request accepted this cycle |
| cpu_op | input | 2 | 00 load, 01 store, 10 barrier, 11 refill read |
| cpu_addr | input | 32 | Request byte address |
| cpu_wdata | input | 32 | Store data |
| rd_valid | output | 1 | Read data return pulse |
| rd_data | output | 32 | Returned read data |
| sync_done | output | 1 | Barrier completion pulse |
| bus_valid | output | 1 | Bus request valid |
| bus_ready | input | 1 | Bus accepts the request |
| bus_we | output | 1 | 1 store, 0 read |
| bus_addr | output | 32 | Bus request address |
| bus_wdata | output | 32 | Bus store data |
| bus_rdata | input | 32 | Bus read data, valid with acceptance of a read |

## Verification
Some properties are checked on every cycle by assertions. These are: a held bus request stays stable, a refill on the bus never collides with a queued line, an ordinary load only goes out on an empty queue, a barrier only completes on an empty queue, and read data follows a read acceptance by one cycle. The exact position of the read among the drained stores can only be shown by the bench's scenarios. The same holds for store ordering, the discarding of work by reset and the full-queue stall. The bench sweeps queue depth against the position of the conflicting line and checks the recorded bus order against a position it computes itself.

// File: rtl/wbyp_pkg.sv
package wbyp_pkg;
    typedef enum logic [1:0] {
        OP_LOAD   = 2'b00,
        OP_STORE  = 2'b01,
        OP_SYNC   = 2'b10,
        OP_REFILL = 2'b11
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ_WAIT,
        ST_READ_RET,
        ST_SYNC_WAIT,
        ST_SYNC_DONE
    } ctl_state_e;
endpackage

// File: rtl/wbyp_fifo.sv
module wbyp_fifo #(
    parameter int DEPTH = 4,
    parameter int AW    = 32,
    parameter int DW    = 32
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        push,
    input  logic [AW-1:0]               push_addr,
    input  logic [DW-1:0]               push_data,
    input  logic                        pop,
    output logic [AW-1:0]               head_addr,
    output logic [DW-1:0]               head_data,
    output logic [$clog2(DEPTH+1)-1:0]  occ,
    output logic                        full,
    output logic                        empty,
    output logic [DEPTH-1:0][AW-1:0]    ent_addr,
    output logic [DEPTH-1:0]            ent_live
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH+1);

    logic [DEPTH-1:0][AW-1:0] addr_q;
    logic [DEPTH-1:0][DW-1:0] data_q;
    logic [PTR_W-1:0]         wr_ptr;
    logic [PTR_W-1:0]         rd_ptr;

    always_ff @(posedge clk) begin
        if (push) begin
            addr_q[wr_ptr] <= push_addr;
            data_q[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ    <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
            unique case ({push, pop})
                2'b10:   occ <= occ + 1'b1;
                2'b01:   occ <= occ - 1'b1;
                default: occ <= occ;
            endcase
        end
    end

    assign head_addr = addr_q[rd_ptr];
    assign head_data = data_q[rd_ptr];
    assign full      = (occ == CNT_W'(DEPTH));
    assign empty     = (occ == '0);
    assign ent_addr  = addr_q;

    for (genvar i = 0; i < DEPTH; i++) begin : g_live
        logic [PTR_W-1:0] rel;
        assign rel         = PTR_W'(i) - rd_ptr;
        assign ent_live[i] = (CNT_W'(rel) < occ);
    end
endmodule

// File: rtl/wbyp_match.sv
module wbyp_match #(
    parameter int DEPTH = 4,
    parameter int AW    = 32,
    parameter int OFF_W = 5
) (
    input  logic [DEPTH-1:0][AW-1:0] ent_addr,
    input  logic [DEPTH-1:0]         ent_live,
    input  logic [AW-1:0]            probe_addr,
    output logic                     hit
);
    localparam logic [AW-1:0] LINE_MASK = ~((AW'(1) << OFF_W) - AW'(1));

    logic [DEPTH-1:0] eq;

    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign eq[i] = ent_live[i] && (((ent_addr[i] ^ probe_addr) & LINE_MASK) == '0);
    end

    assign hit = |eq;
endmodule

// File: rtl/wbyp_ctrl.sv
module wbyp_ctrl
    import wbyp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cpu_valid,
    input  logic [1:0] cpu_op,
    input  logic       fifo_full,
    input  logic       fifo_empty,
    input  logic       rd_hit,
    input  logic       pend_refill,
    input  logic       bus_ready,
    output logic       cpu_ready,
    output logic       push,
    output logic       capture_rd,
    output logic       pop,
    output logic       rd_sel,
    output logic       bus_valid,
    output logic       rd_valid,
    output logic       sync_done
);
    ctl_state_e state_q, state_d;
    op_e        op;
    logic       accept;
    logic       wlock_q;

    assign op = op_e'(cpu_op);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            wlock_q <= 1'b0;
        end else begin
            state_q <= state_d;
            wlock_q <= !rd_sel && !fifo_empty && !bus_ready;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    unique case (op)
                        OP_LOAD, OP_REFILL: state_d = ST_READ_WAIT;
                        OP_SYNC:            state_d = ST_SYNC_WAIT;
                        OP_STORE:           state_d = ST_IDLE;
                    endcase
                end
            end
            ST_READ_WAIT: if (rd_sel && bus_ready) state_d = ST_READ_RET;
            ST_READ_RET:  state_d = ST_IDLE;
            ST_SYNC_WAIT: if (fifo_empty) state_d = ST_SYNC_DONE;
            ST_SYNC_DONE: state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        cpu_ready  = (state_q == ST_IDLE) && !(op == OP_STORE && fifo_full);
        accept     = cpu_valid && cpu_ready;
        push       = accept && (op == OP_STORE);
        capture_rd = accept && (op == OP_LOAD || op == OP_REFILL);
        rd_sel     = (state_q == ST_READ_WAIT) && !wlock_q &&
                     (pend_refill ? !rd_hit : fifo_empty);
        bus_valid  = rd_sel || !fifo_empty;
        pop        = !rd_sel && !fifo_empty && bus_ready;
        rd_valid   = (state_q == ST_READ_RET);
        sync_done  = (state_q == ST_SYNC_DONE);
    end
endmodule

// File: rtl/wbyp_top.sv
module wbyp_top
    import wbyp_pkg::*;
#(
    parameter int DEPTH      = 4,
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter int LINE_BYTES = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cpu_valid,
    output logic          cpu_ready,
    input  logic [1:0]    cpu_op,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic          sync_done,
    output logic          bus_valid,
    input  logic          bus_ready,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata
);
    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int CNT_W = $clog2(DEPTH+1);

    logic                     push, pop, capture_rd, rd_sel;
    logic                     fifo_full, fifo_empty, rd_hit;
    logic [AW-1:0]            head_addr;
    logic [DW-1:0]            head_data;
    logic [CNT_W-1:0]         occ;
    logic [DEPTH-1:0][AW-1:0] ent_addr;
    logic [DEPTH-1:0]         ent_live;
    logic [AW-1:0]            pend_addr;
    logic                     pend_refill;
    logic [DW-1:0]            rd_data_q;

    wbyp_fifo #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) fifo_i (
        .clk(clk), .rst(rst),
        .push(push), .push_addr(cpu_addr), .push_data(cpu_wdata),
        .pop(pop), .head_addr(head_addr), .head_data(head_data),
        .occ(occ), .full(fifo_full), .empty(fifo_empty),
        .ent_addr(ent_addr), .ent_live(ent_live)
    );

    wbyp_match #(.DEPTH(DEPTH), .AW(AW), .OFF_W(OFF_W)) match_i (
        .ent_addr(ent_addr), .ent_live(ent_live),
        .probe_addr(pend_addr), .hit(rd_hit)
    );

    wbyp_ctrl ctrl_i (
        .clk(clk), .rst(rst),
        .cpu_valid(cpu_valid), .cpu_op(cpu_op),
        .fifo_full(fifo_full), .fifo_empty(fifo_empty),
        .rd_hit(rd_hit), .pend_refill(pend_refill), .bus_ready(bus_ready),
        .cpu_ready(cpu_ready), .push(push), .capture_rd(capture_rd),
        .pop(pop), .rd_sel(rd_sel), .bus_valid(bus_valid),
        .rd_valid(rd_valid), .sync_done(sync_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_addr   <= '0;
            pend_refill <= 1'b0;
            rd_data_q   <= '0;
        end else begin
            if (capture_rd) begin
                pend_addr   <= cpu_addr;
                pend_refill <= (op_e'(cpu_op) == OP_REFILL);
            end
            if (rd_sel && bus_ready) rd_data_q <= bus_rdata;
        end
    end

    assign bus_we    = !rd_sel;
    assign bus_addr  = rd_sel ? pend_addr : head_addr;
    assign bus_wdata = rd_sel ? '0 : head_data;
    assign rd_data   = rd_data_q;
endmodule

// File: rtl/wbyp_checks.sv
module wbyp_checks #(
    parameter int DEPTH = 4,
    parameter int AW    = 32,
    parameter int DW    = 32
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       cpu_valid,
    input logic                       cpu_ready,
    input logic [1:0]                 cpu_op,
    input logic                       rd_valid,
    input logic                       sync_done,
    input logic                       bus_valid,
    input logic                       bus_ready,
    input logic                       bus_we,
    input logic [AW-1:0]              bus_addr,
    input logic [DW-1:0]              bus_wdata,
    input logic [$clog2(DEPTH+1)-1:0] occ,
    input logic                       rd_hit,
    input logic                       pend_refill
);
    localparam int CNT_W = $clog2(DEPTH+1);

    assert_store_stall_R1: assert property (@(posedge clk) disable iff (rst)
        (cpu_valid && cpu_op == 2'b01 && occ == CNT_W'(DEPTH)) |-> !cpu_ready);

    assert_no_overflow_R1: assert property (@(posedge clk) disable iff (rst)
        occ <= CNT_W'(DEPTH));

    assert_refill_clean_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_we && pend_refill) |-> !rd_hit);

    assert_load_after_drain_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_we && !pend_refill) |-> (occ == '0));

    assert_read_return_R6: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(bus_valid && bus_ready && !bus_we));

    assert_sync_drained_R7: assert property (@(posedge clk) disable iff (rst)
        sync_done |-> (occ == '0));

    assert_core_held_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_we) |-> !cpu_ready);

    assert_bus_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_ready) |=>
            (bus_valid && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata)));

    assert_reset_empty_R10: assert property (@(posedge clk)
        rst |=> (occ == '0 && !bus_valid));
endmodule

bind wbyp_top wbyp_checks #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) chk_i (
    .clk(clk), .rst(rst), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
    .cpu_op(cpu_op), .rd_valid(rd_valid), .sync_done(sync_done),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .occ(occ),
    .rd_hit(rd_hit), .pend_refill(pend_refill)
);

// File: tb/wbyp_top_tb_top.sv
module wbyp_top_tb_top;
    localparam logic [31:0] RKEY = 32'h5A5A_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_valid = 1'b0;
    logic        cpu_ready;
    logic [1:0]  cpu_op = 2'b00;
    logic [31:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        sync_done;
    logic        bus_valid;
    logic        bus_ready = 1'b0;
    logic        bus_we;
    logic [31:0] bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;

    int checks = 0;
    int errors = 0;

    logic        log_we   [16];
    logic [31:0] log_addr [16];
    logic [31:0] log_data [16];
    int          log_n = 0;

    always #4 clk = ~clk;

    assign bus_rdata = bus_addr ^ RKEY;

    wbyp_top dut_i (
        .clk(clk), .rst(rst), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
        .cpu_op(cpu_op), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .sync_done(sync_done),
        .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    always @(posedge clk) begin
        if (!rst && bus_valid && bus_ready && log_n < 16) begin
            log_we[log_n]   = bus_we;
            log_addr[log_n] = bus_addr;
            log_data[log_n] = bus_wdata;
            log_n           = log_n + 1;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        cpu_valid = 1'b0;
        bus_ready = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        log_n = 0;
    endtask

    task automatic send(input logic [1:0] op, input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        cpu_valid = 1'b1;
        cpu_op    = op;
        cpu_addr  = a;
        cpu_wdata = d;
        #1;
        for (int g = 0; g < 50 && !cpu_ready; g++) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        cpu_valid = 1'b0;
    endtask

    function automatic logic [31:0] st_addr(input int i);
        return 32'h0000_1000 + 32'(i) * 32 + 32'd4;
    endfunction

    // Sweep: n queued stores, read conflicting with store k (k<0: none)
    task automatic run_case(input int n, input int k, input bit refill);
        logic [31:0] raddr;
        int          exp_idx;
        int          wi;
        bit          got;
        do_reset();
        for (int i = 0; i < n; i++) send(2'b01, st_addr(i), 32'hD000_0000 + 32'(i));
        if (n == 4) begin
            @(negedge clk);
            cpu_valid = 1'b1; cpu_op = 2'b01; cpu_addr = 32'h9000; #1;
            check(cpu_ready == 1'b0, "R1 store taken while full", 32'(cpu_ready), 0);
            cpu_valid = 1'b0;
        end
        raddr = (k < 0) ? 32'h0000_8000 : (32'h0000_1000 + 32'(k) * 32 + 32'd8);
        send(refill ? 2'b11 : 2'b00, raddr, 32'h0);
        @(negedge clk);
        cpu_valid = 1'b1; cpu_op = 2'b01; cpu_addr = 32'h9100; #1;
        check(cpu_ready == 1'b0, "R8 core not held during read", 32'(cpu_ready), 0);
        check(bus_valid && bus_we && bus_addr == st_addr(0), "R9 held head store changed",
              bus_addr, st_addr(0));
        cpu_valid = 1'b0;
        @(negedge clk);
        bus_ready = 1'b1;
        got = 1'b0;
        for (int g = 0; g < 40 && !got; g++) begin
            @(negedge clk);
            if (rd_valid) begin
                got = 1'b1;
                check(rd_data == (raddr ^ RKEY), "R6 read data", rd_data, raddr ^ RKEY);
            end
        end
        check(got, "R6 no read return", 32'(got), 1);
        repeat (6) @(negedge clk);
        check(log_n == n + 1, "R2 bus transfer count", 32'(log_n), 32'(n + 1));
        exp_idx = !refill ? n : ((k < 0) ? 1 : k + 1);
        wi = 0;
        for (int p = 0; p < n + 1 && p < log_n; p++) begin
            if (p == exp_idx) begin
                check(!log_we[p] && log_addr[p] == raddr,
                      refill ? ((k < 0) ? "R3 refill bypass position" : "R4 conflicting refill position")
                             : "R5 load position",
                      log_addr[p], raddr);
            end else begin
                check(log_we[p] && log_addr[p] == st_addr(wi) &&
                      log_data[p] == 32'hD000_0000 + 32'(wi),
                      "R2 store order", log_addr[p], st_addr(wi));
                wi++;
            end
        end
        bus_ready = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        bit seen;
        do_reset();
        @(negedge clk); #1;
        check(cpu_ready && !bus_valid && !rd_valid && !sync_done, "R10 reset state",
              {28'h0, cpu_ready, bus_valid, rd_valid, sync_done}, 32'h8);

        for (int n = 1; n <= 4; n++) begin
            for (int k = -1; k < n; k++) run_case(n, k, 1'b1);
            run_case(n, -1, 1'b0);
            run_case(n, n - 1, 1'b0);
        end

        // Barrier waits for queued stores (R7)
        do_reset();
        for (int i = 0; i < 3; i++) send(2'b01, st_addr(i), 32'hD000_0000 + 32'(i));
        send(2'b10, 32'h0, 32'h0);
        seen = 1'b0;
        repeat (5) begin
            @(negedge clk);
            if (sync_done) seen = 1'b1;
        end
        check(!seen, "R7 barrier done with stores queued", 32'(seen), 0);
        bus_ready = 1'b1;
        seen = 1'b0;
        for (int g = 0; g < 30 && !seen; g++) begin
            @(negedge clk);
            if (sync_done) begin
                seen = 1'b1;
                check(log_n == 3, "R7 barrier before drain", 32'(log_n), 3);
            end
        end
        check(seen, "R7 barrier never done", 32'(seen), 1);
        @(negedge clk);
        check(!sync_done, "R7 barrier pulse width", 32'(sync_done), 0);

        // Reset discards queued stores and barrier (R10)
        do_reset();
        for (int i = 0; i < 2; i++) send(2'b01, st_addr(i), 32'hD000_0000 + 32'(i));
        send(2'b10, 32'h0, 32'h0);
        do_reset();
        @(negedge clk); #1;
        check(!bus_valid && cpu_ready, "R10 state after reset", {30'h0, bus_valid, cpu_ready}, 32'h1);
        bus_ready = 1'b1;
        seen = 1'b0;
        repeat (8) begin
            @(negedge clk);
            if (sync_done) seen = 1'b1;
        end
        check(log_n == 0, "R10 discarded store issued", 32'(log_n), 0);
        check(!seen, "R10 discarded barrier completed", 32'(seen), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule